// File: doc/BRIEF.md
# Carry-Free Multi-Operand Stream Accumulator

This block totals a stream of unsigned binary operands. Each arriving operand is split into radix-2^M digits, which needs only wiring. It is then added into a running total held in a redundant digit form. In that form every digit lies in the range -1 to 2^M-1. The adder is carry-free: a digit of the result depends only on its own column and the two columns below it. Each accumulation step therefore takes one clock cycle whatever the operand width. The total is converted back to binary only once, after the final operand, in one extra registered cycle.

A stream is a sequence of beats, where a beat is a cycle with `in_valid` high. The first beat of a stream carries `in_start`, which discards any earlier total. The final beat carries `in_last`. A beat can carry both flags, which makes a one-operand stream. The result appears on `out_sum` with a one-cycle `out_valid` pulse. A new stream may begin in the cycle right after a final beat.

The controller has three states:
- IDLE: waits for a beat that carries the first-operand flag.
- ACCUM: adds every beat into the running total.
- CONVERT: the redundant total is being turned into binary.

Its transitions are:
- IDLE to ACCUM on a first beat without the final flag. IDLE to CONVERT on a beat that carries both flags.
- ACCUM to CONVERT on a final beat. ACCUM stays in ACCUM on any other beat or an empty cycle.
- CONVERT to ACCUM or CONVERT when a new first beat arrives. CONVERT to IDLE otherwise.

Top module: `rsd_stream_adder`

## Requirements
- R1: After reset `out_valid` is 0 and `out_sum` is 0.
- R2: For a stream of 1 to MAX_OPS operands, `out_sum` equals the plain integer sum of the operands. Its width is SUM_W = M*(ceil(OP_W/M) + e) bits, where e is the least integer with 2^(M*e) >= MAX_OPS. With the defaults this is 22 bits.
- R3: When the final beat is sampled at clock edge k, `out_valid` is high from edge k+1 until edge k+2 and low in the cycle before and the cycle after.
- R4: A beat carrying `in_start` begins a new total, and the operands of an unfinished earlier stream do not contribute.
- R5: A beat without `in_start` arriving in IDLE (or CONVERT) is ignored: no output is produced and the next stream's sum is unaffected.
- R6: Cycles with `in_valid` low between beats of a stream change neither the total nor `out_valid`.
- R7: A stream of one operand (both flags on one beat) returns that operand unchanged.
- R8: Every digit of the stored running total stays within -1 to 2^M-1.
- R9: MAX_OPS operands all equal to 2^OP_W-1 are summed without loss. The adder's top transfer is always 0 for streams within MAX_OPS.
- R10: Streams may follow back to back. Two one-operand streams on consecutive cycles give two consecutive `out_valid` cycles with each operand in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Beat qualifier |
| in_start | input | 1 | Beat is the first operand of a stream |
| in_last | input | 1 | Beat is the final operand of a stream |
| in_data | input | OP_W | Unsigned operand |
| out_valid | output | 1 | One-cycle result strobe |
| out_sum | output | SUM_W | Binary total of the stream |

## Verification
The assertions assume that no stream carries more than MAX_OPS operands. They also assume that streams are framed by a first beat, because the overflow and digit-range properties hold only for totals the accumulator was sized for. The random stimulus draws each stream length from 1 to MAX_OPS and always flags the first beat. The over-length case is never driven. The directed cases cover streams with a missing start, abandoned streams and gaps, and each of these stays within that bound as well.

// File: rtl/rsd_stream_pkg.sv
package rsd_stream_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACCUM   = 2'd1,
        ST_CONVERT = 2'd2
    } acc_state_e;

    // least e with (2^m)^e >= count
    function automatic int guard_digits(input int count, input int m);
        int     e;
        longint span;
        e    = 0;
        span = 1;
        while (span < longint'(count)) begin
            span = span << m;
            e++;
        end
        return e;
    endfunction

endpackage

// File: rtl/rsd_cf_adder.sv
// Carry-free add of a redundant operand (digits -1..R-1) and a canonical
// operand (digits 0..R-1); result digits stay in -1..R-1.
module rsd_cf_adder #(
    parameter int M = 2,
    parameter int N = 11
) (
    input  logic [N-1:0][M:0]   red_in,
    input  logic [N-1:0][M-1:0] can_in,
    output logic [N-1:0][M:0]   sum_out,
    output logic                top_xfer
);
    localparam int R = 1 << M;
    localparam logic signed [M+1:0] RM1 = (M+2)'(R - 1);
    localparam logic signed [M+1:0] RV  = (M+2)'(R);

    logic [N-1:0] est;   // column sum below R-1
    logic [N-1:0] xfer;  // transfer into the next column

    for (genvar j = 0; j < N; j++) begin : g_dig
        logic signed [M+1:0] a_ext;
        logic signed [M+1:0] b_ext;
        logic signed [M+1:0] z;
        logic signed [M+1:0] mu;
        logic signed [M+1:0] sfull;
        logic                est_below;
        logic                xfer_in;

        assign a_ext = {red_in[j][M], red_in[j]};
        assign b_ext = {2'b00, can_in[j]};
        assign z     = a_ext + b_ext;
        assign est[j] = (z < RM1);

        if (j == 0) begin : g_lsd
            assign est_below = 1'b1;
            assign xfer_in   = 1'b0;
        end else begin : g_upper
            assign est_below = est[j-1];
            assign xfer_in   = xfer[j-1];
        end

        assign xfer[j] = !(est[j] || ((z == RM1) && est_below));
        assign mu      = xfer[j] ? (z - RV) : z;
        assign sfull   = mu + (M+2)'(xfer_in);
        assign sum_out[j] = sfull[M:0];
    end

    assign top_xfer = xfer[N-1];

endmodule

// File: rtl/rsd_to_bin.sv
// Redundant digits to binary: positive magnitudes minus the -1 digits.
module rsd_to_bin #(
    parameter int M = 2,
    parameter int N = 11
) (
    input  logic [N-1:0][M:0] dig_in,
    output logic [N*M-1:0]    bin_out
);
    localparam int W = N * M;

    logic [W-1:0] pos_part;
    logic [W-1:0] neg_part;

    for (genvar j = 0; j < N; j++) begin : g_split
        assign pos_part[j*M +: M] = dig_in[j][M] ? '0 : dig_in[j][M-1:0];
        if (M > 1) begin : g_wide
            assign neg_part[j*M +: M] = {{(M-1){1'b0}}, dig_in[j][M]};
        end else begin : g_narrow
            assign neg_part[j*M] = dig_in[j][M];
        end
    end

    assign bin_out = pos_part - neg_part;

endmodule

// File: rtl/rsd_stream_adder.sv
module rsd_stream_adder
    import rsd_stream_pkg::*;
#(
    parameter int OP_W       = 16,
    parameter int DIGIT_BITS = 2,
    parameter int MAX_OPS    = 20,
    localparam int M     = DIGIT_BITS,
    localparam int Q     = (OP_W + M - 1) / M,
    localparam int EXT   = guard_digits(MAX_OPS, M),
    localparam int N     = Q + EXT,
    localparam int SUM_W = N * M
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_start,
    input  logic             in_last,
    input  logic [OP_W-1:0]  in_data,
    output logic             out_valid,
    output logic [SUM_W-1:0] out_sum
);

    acc_state_e state_q, state_d;

    logic [N-1:0][M:0]   acc_q;
    logic [N-1:0][M:0]   fin_q;
    logic [N-1:0][M:0]   base_dig;
    logic [N-1:0][M-1:0] op_dig;
    logic [N-1:0][M:0]   add_dig;
    logic                add_top;
    logic [SUM_W-1:0]    conv_bin;
    logic                accept;

    assign op_dig   = SUM_W'(in_data);
    assign base_dig = in_start ? '0 : acc_q;
    assign accept   = in_valid && (in_start || (state_q == ST_ACCUM));

    rsd_cf_adder #(.M(M), .N(N)) u_add (
        .red_in   (base_dig),
        .can_in   (op_dig),
        .sum_out  (add_dig),
        .top_xfer (add_top)
    );

    rsd_to_bin #(.M(M), .N(N)) u_conv (
        .dig_in  (fin_q),
        .bin_out (conv_bin)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_CONVERT: begin
                if (accept) state_d = in_last ? ST_CONVERT : ST_ACCUM;
                else        state_d = ST_IDLE;
            end
            ST_ACCUM: begin
                if (accept && in_last) state_d = ST_CONVERT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // running total and final-total staging
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            fin_q <= '0;
        end else if (accept) begin
            if (in_last) fin_q <= add_dig;
            else         acc_q <= add_dig;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sum   <= '0;
        end else begin
            out_valid <= (state_q == ST_CONVERT);
            if (state_q == ST_CONVERT) out_sum <= conv_bin;
        end
    end

    // ---------------- assertions ----------------
    p_valid_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && in_last) |=> ##1 out_valid);

    p_no_early_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_CONVERT) |=> !out_valid);

    p_idle_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != ST_ACCUM) && in_valid && !in_start) |=> (state_q == ST_IDLE));

    p_gap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_ACCUM) && !in_valid) |=> ($stable(acc_q) && (state_q == ST_ACCUM)));

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> !add_top);

    for (genvar j = 0; j < N; j++) begin : g_chk
        p_digit_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ($signed(acc_q[j]) >= -1) && ($signed(fin_q[j]) >= -1));
    end

endmodule

// File: tb/rsd_stream_adder_tb.sv
`timescale 1ns/1ps
module rsd_stream_adder_tb;

    localparam int OP_W     = 16;
    localparam int M        = 2;
    localparam int MAX_OPS  = 20;
    localparam int SUM_W    = 22;   // R2: 2*(8+3)
    localparam longint OP_MAX = (64'd1 << OP_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_start = 1'b0;
    logic             in_last = 1'b0;
    logic [OP_W-1:0]  in_data = '0;
    logic             out_valid;
    logic [SUM_W-1:0] out_sum;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    rsd_stream_adder #(.OP_W(OP_W), .DIGIT_BITS(M), .MAX_OPS(MAX_OPS)) u_dut (
        .clk, .rst_n, .in_valid, .in_start, .in_last, .in_data,
        .out_valid, .out_sum
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle_beat();
        @(negedge clk);
        in_valid = 1'b0; in_start = 1'b0; in_last = 1'b0;
    endtask

    // mode 0 random operands, mode 1 all-ones operands
    task automatic run_stream(input int len, input int max_gap, input int mode,
                              input string req);
        longint total = 0;
        for (int i = 0; i < len; i++) begin
            longint v = (mode == 1) ? OP_MAX : longint'($urandom_range(0, 32'(OP_MAX)));
            total += v;
            @(negedge clk);
            in_valid = 1'b1;
            in_start = (i == 0);
            in_last  = (i == len - 1);
            in_data  = OP_W'(v);
            if (i != len - 1 && max_gap > 0) begin
                int g = $urandom_range(0, max_gap);
                for (int k = 0; k < g; k++) begin
                    idle_beat();
                    chk("R6 gap no output", longint'(out_valid), 0);
                end
            end
        end
        idle_beat();
        chk("R3 low before pulse", longint'(out_valid), 0);
        @(negedge clk);
        chk("R3 pulse", longint'(out_valid), 1);
        chk(req, longint'(out_sum), total);
        @(negedge clk);
        chk("R3 low after pulse", longint'(out_valid), 0);
    endtask

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        chk("R1 valid", longint'(out_valid), 0);
        chk("R1 sum", longint'(out_sum), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after release", longint'(out_valid), 0);

        // R7 single operand
        run_stream(1, 0, 0, "R7 single operand");
        run_stream(1, 0, 1, "R7 single max operand");

        // R9 maximal stream
        run_stream(MAX_OPS, 0, 1, "R9 max operands all ones");

        // R5 beats without start are ignored
        @(negedge clk);
        in_valid = 1'b1; in_start = 1'b0; in_last = 1'b1; in_data = 16'h1234;
        @(negedge clk);
        in_data = 16'h00FF;
        idle_beat();
        @(negedge clk);
        chk("R5 no output from unstarted beats", longint'(out_valid), 0);
        run_stream(3, 0, 0, "R5 sum after ignored beats");

        // R4 abandoned stream then restart
        @(negedge clk);
        in_valid = 1'b1; in_start = 1'b1; in_last = 1'b0; in_data = 16'hAAAA;
        @(negedge clk);
        in_start = 1'b0; in_data = 16'h5555;
        idle_beat();
        chk("R4 no output from open stream", longint'(out_valid), 0);
        run_stream(4, 1, 0, "R4 restart discards old total");

        // R10 back-to-back single-operand streams
        @(negedge clk);
        in_valid = 1'b1; in_start = 1'b1; in_last = 1'b1; in_data = 16'hBEEF;
        @(negedge clk);
        in_data = 16'h0042;
        idle_beat();
        chk("R10 first pulse", longint'(out_valid), 1);
        chk("R10 first sum", longint'(out_sum), 64'hBEEF);
        @(negedge clk);
        chk("R10 second pulse", longint'(out_valid), 1);
        chk("R10 second sum", longint'(out_sum), 64'h0042);
        @(negedge clk);
        chk("R10 pulse ends", longint'(out_valid), 0);

        // R6 gaps, R2 random streams
        run_stream(6, 3, 0, "R6 sum with gaps");
        for (int s = 0; s < 40; s++) begin
            run_stream($urandom_range(1, MAX_OPS), 2, 0, "R2 random stream sum");
        end
        // R8 exercised by digit-range assertions on every stream above

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule